// File: doc/BRIEF.md
# Indexed-Colour Framebuffer Control Registers

This block is the register front end of an 8-bit indexed-colour display engine. A host reaches it through a plain word bus: an address, a 32-bit write word, and separate read and write strobes. It stores the state that the pixel pipeline and the scanout logic use:
- a 256-entry colour lookup table,
- a three-colour cursor lookup table,
- a 512-word cursor bitmap,
- the control word, the frame start address, the cursor position and the scaled display width and line count.

All three tables use an 8-byte stride.

The pixel pipeline reads the tables through combinational lookup ports. It reads the other registers directly as decoded outputs:
- a blank flag,
- a cursor-disable flag,
- a decoded bits-per-pixel value.

Every bus write produces a one-cycle interrupt-acknowledge pulse. A write to the soft-reset offset clears all stored state and produces a one-cycle reset pulse. Writes to the video-timing offsets are accepted and change nothing. An access to any offset the block does not serve returns zero and raises a one-cycle error flag.

Top module: `fbctl_regs`

## Requirements
- R1: A write to byte offset 0x800..0xFFF stores data bits 23:16/15:8/7:0 as red/green/blue of colour entry (offset-0x800)>>3. Data bits 31:24 are discarded. The entry appears on `pix_rgb` for `pix_idx` from the next cycle. Reads of this range are unserved.
- R2: Cursor colours 0, 1 and 2 sit at offsets 0x508, 0x510 and 0x518, packed as in R1. They read back as {8'h00, rgb}. `cur_rgb` shows colour `cur_sel`, and it is zero when `cur_sel` is 3.
- R3: A write to offset 0x1000..0x1FFF stores data bits 15:0 as cursor bitmap word (offset-0x1000)>>3. A read of that word returns it zero-extended. `pat_word` shows word `pat_idx`.
- R4: A write to 0x118 sets `width_px` to data*4, modulo 2^32. A read of 0x118 returns `width_px`/4.
- R5: A write to 0x150 sets `height_ln` to data/2, rounded down. A read of 0x150 returns `height_ln`*2.
- R6: A write to 0x300 sets the control word, and a read of 0x300 returns it. `blank` is bit 10 and `cursor_off` is bit 23. `depth_bpp` decodes bits 22:20 as codes 0..7 giving 1, 2, 4, 8, 15, 16, 0 and 0.
- R7: A write to 0x400 sets `top_addr`, and a write to 0x638 sets `cursor_pos`. Both hold the full data word. Reads of 0x400 and 0x638 are unserved.
- R8: A write to 0x100000 clears all tables and all registers in the next cycle. In that same cycle `soft_rst` is high for exactly one cycle.
- R9: Writes to offsets 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no state and raise no error.
- R10: `irq_clr` is high for the one cycle after every write strobe, whatever the offset, and low otherwise.
- R11: An unserved read returns zero. An unserved write changes nothing. In either case `err_pulse` is high for the one cycle after the strobe.
- R12: Read data is registered. `rdata_vld` is high exactly the cycle after `rd_en`, and `rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 21 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rdata_vld | output | 1 | Read data valid |
| err_pulse | output | 1 | Unserved access flag, one cycle |
| irq_clr | output | 1 | Interrupt acknowledge pulse |
| soft_rst | output | 1 | Soft-reset pulse |
| pix_idx | input | 8 | Colour lookup index |
| pix_rgb | output | 24 | Colour lookup result |
| cur_sel | input | 2 | Cursor colour select |
| cur_rgb | output | 24 | Cursor colour result |
| pat_idx | input | 9 | Cursor bitmap word index |
| pat_word | output | 16 | Cursor bitmap word |
| ctrl_word | output | 32 | Control register |
| blank | output | 1 | Force-blank flag |
| cursor_off | output | 1 | Cursor disable flag |
| depth_bpp | output | 5 | Decoded bits per pixel |
| top_addr | output | 32 | Frame start address |
| cursor_pos | output | 32 | Cursor position word |
| width_px | output | 32 | Display width in pixels |
| height_ln | output | 32 | Display height in lines |

## Verification
Two kinds of internal fault show up at the ports one cycle after the access that exposes them:
- a wrong index slice or region boundary puts the wrong value on a lookup port in the cycle after the write;
- a scaling error in width or line count shows on `width_px` or `height_ln` at once, and again in the read-back one cycle after the read strobe.

Stale table contents after a soft reset show on the lookup ports in the same cycle that `soft_rst` is high. A decode that treats a timing or unserved offset as served, or the other way round, is visible through `err_pulse` in the cycle after the strobe.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_TIMING, RG_CPAL, RG_CURPAL, RG_PAT,
    RG_WIDTH, RG_HEIGHT, RG_CTRL, RG_TOP, RG_POS, RG_SRST
  } region_e;

  // Control word field positions (decoded by the scanout side)
  localparam int CTRL_BLANK_BIT  = 10;
  localparam int CTRL_CUROFF_BIT = 23;
  localparam int CTRL_DEPTH_LSB  = 20;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    logic [4:0] r;
    case (code)
      3'd0: r = 5'd1;
      3'd1: r = 5'd2;
      3'd2: r = 5'd4;
      3'd3: r = 5'd8;
      3'd4: r = 5'd15;
      3'd5: r = 5'd16;
      default: r = 5'd0;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] width_from_bus(input logic [31:0] d);
    return {d[29:0], 2'b00};
  endfunction

  function automatic logic [31:0] width_to_bus(input logic [31:0] w);
    return {2'b00, w[31:2]};
  endfunction

  function automatic logic [31:0] height_from_bus(input logic [31:0] d);
    return {1'b0, d[31:1]};
  endfunction

  function automatic logic [31:0] height_to_bus(input logic [31:0] h);
    return {h[30:0], 1'b0};
  endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
  import fbctl_pkg::*;
#(
  parameter int AW    = 21,
  parameter int IDX_W = 9
) (
  input  logic [AW-1:0]    addr,
  output region_e          region,
  output logic [IDX_W-1:0] idx
);
  localparam logic [AW-1:0] CPAL_LO = AW'(12'h800);
  localparam logic [AW-1:0] CPAL_HI = AW'(12'hFFF);
  localparam logic [AW-1:0] PAT_LO  = AW'(16'h1000);
  localparam logic [AW-1:0] PAT_HI  = AW'(16'h1FFF);
  localparam logic [AW-1:0] CUR_LO  = AW'(12'h508);
  localparam logic [AW-1:0] CUR_HI  = AW'(12'h51F);
  localparam logic [AW-1:0] A_WIDTH = AW'(12'h118);
  localparam logic [AW-1:0] A_HGT   = AW'(12'h150);
  localparam logic [AW-1:0] A_CTRL  = AW'(12'h300);
  localparam logic [AW-1:0] A_TOP   = AW'(12'h400);
  localparam logic [AW-1:0] A_POS   = AW'(12'h638);
  localparam logic [AW-1:0] A_SRST  = AW'(24'h100000);
  localparam logic [AW-1:0] TM_LO   = AW'(12'h108);
  localparam logic [AW-1:0] TM_HI   = AW'(12'h170);
  localparam logic [AW-1:0] TM_MASK = AW'(12'h200);

  logic timing_hit;
  assign timing_hit = (addr == '0) || (addr == TM_MASK) ||
                      (addr >= TM_LO && addr <= TM_HI && addr[2:0] == 3'b000 &&
                       addr != A_WIDTH && addr != A_HGT);

  always_comb begin
    region = RG_NONE;
    idx    = '0;
    if (addr >= CPAL_LO && addr <= CPAL_HI) begin
      region = RG_CPAL;
      idx    = IDX_W'((addr - CPAL_LO) >> 3);
    end else if (addr >= PAT_LO && addr <= PAT_HI) begin
      region = RG_PAT;
      idx    = IDX_W'((addr - PAT_LO) >> 3);
    end else if (addr >= CUR_LO && addr <= CUR_HI) begin
      region = RG_CURPAL;
      idx    = IDX_W'((addr - CUR_LO) >> 3);
    end else if (addr == A_WIDTH) region = RG_WIDTH;
    else if (addr == A_HGT)       region = RG_HEIGHT;
    else if (addr == A_CTRL)      region = RG_CTRL;
    else if (addr == A_TOP)       region = RG_TOP;
    else if (addr == A_POS)       region = RG_POS;
    else if (addr == A_SRST)      region = RG_SRST;
    else if (timing_hit)          region = RG_TIMING;
  end
endmodule

// File: rtl/fbctl_table.sv
module fbctl_table #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 24,
  parameter int NRD   = 1,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       we,
  input  logic [IW-1:0]              widx,
  input  logic [WIDTH-1:0]           wdat,
  input  logic [NRD-1:0][IW-1:0]     ridx,
  output logic [NRD-1:0][WIDTH-1:0]  rdat
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[e] <= '0;
      else if (clr)                         mem[e] <= '0;
      else if (we && widx == IW'(e))        mem[e] <= wdat;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdat[p] = (32'(ridx[p]) < DEPTH) ? mem[ridx[p]] : '0;
  end
endmodule

// File: rtl/fbctl_scalars.sv
module fbctl_scalars
  import fbctl_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we_ctrl,
  input  logic          we_top,
  input  logic          we_pos,
  input  logic          we_width,
  input  logic          we_height,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] top_q,
  output logic [DW-1:0] pos_q,
  output logic [DW-1:0] width_q,
  output logic [DW-1:0] height_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; top_q <= '0; pos_q <= '0; width_q <= '0; height_q <= '0;
    end else if (clr) begin
      ctrl_q <= '0; top_q <= '0; pos_q <= '0; width_q <= '0; height_q <= '0;
    end else begin
      if (we_ctrl)   ctrl_q   <= wdata;
      if (we_top)    top_q    <= wdata;
      if (we_pos)    pos_q    <= wdata;
      if (we_width)  width_q  <= width_from_bus(wdata);
      if (we_height) height_q <= height_from_bus(wdata);
    end
  end
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
  import fbctl_pkg::*;
#(
  parameter int AW      = 21,
  parameter int DW      = 32,
  parameter int CPAL_N  = 256,
  parameter int CUR_N   = 3,
  parameter int PAT_N   = 512,
  parameter int RGB_W   = 24,
  parameter int PAT_W   = 16,
  localparam int CPAL_IW = $clog2(CPAL_N),
  localparam int CUR_IW  = $clog2(CUR_N),
  localparam int PAT_IW  = $clog2(PAT_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic               rdata_vld,
  output logic               err_pulse,
  output logic               irq_clr,
  output logic               soft_rst,
  input  logic [CPAL_IW-1:0] pix_idx,
  output logic [RGB_W-1:0]   pix_rgb,
  input  logic [CUR_IW-1:0]  cur_sel,
  output logic [RGB_W-1:0]   cur_rgb,
  input  logic [PAT_IW-1:0]  pat_idx,
  output logic [PAT_W-1:0]   pat_word,
  output logic [DW-1:0]      ctrl_word,
  output logic               blank,
  output logic               cursor_off,
  output logic [4:0]         depth_bpp,
  output logic [DW-1:0]      top_addr,
  output logic [DW-1:0]      cursor_pos,
  output logic [DW-1:0]      width_px,
  output logic [DW-1:0]      height_ln
);
  localparam int IDX_W = PAT_IW;

  region_e          region;
  logic [IDX_W-1:0] idx;

  fbctl_decode #(.AW(AW), .IDX_W(IDX_W)) u_dec (
    .addr(addr), .region(region), .idx(idx)
  );

  // Named events for the checker
  logic wr_mapped, rd_mapped, timing_wr, srst_wr;
  assign wr_mapped = (region != RG_NONE);
  assign rd_mapped = (region == RG_CURPAL) || (region == RG_PAT) ||
                     (region == RG_WIDTH)  || (region == RG_HEIGHT) ||
                     (region == RG_CTRL);
  assign timing_wr = wr_en && (region == RG_TIMING);
  assign srst_wr   = wr_en && (region == RG_SRST);

  logic [0:0][RGB_W-1:0] cpal_rd;
  logic [1:0][RGB_W-1:0] cur_rd;
  logic [1:0][PAT_W-1:0] pat_rd;

  fbctl_table #(.DEPTH(CPAL_N), .WIDTH(RGB_W), .NRD(1)) u_cpal (
    .clk(clk), .rst_n(rst_n), .clr(srst_wr),
    .we(wr_en && region == RG_CPAL), .widx(idx[CPAL_IW-1:0]),
    .wdat(wdata[RGB_W-1:0]), .ridx(pix_idx), .rdat(cpal_rd)
  );

  fbctl_table #(.DEPTH(CUR_N), .WIDTH(RGB_W), .NRD(2)) u_curpal (
    .clk(clk), .rst_n(rst_n), .clr(srst_wr),
    .we(wr_en && region == RG_CURPAL), .widx(idx[CUR_IW-1:0]),
    .wdat(wdata[RGB_W-1:0]), .ridx({idx[CUR_IW-1:0], cur_sel}), .rdat(cur_rd)
  );

  fbctl_table #(.DEPTH(PAT_N), .WIDTH(PAT_W), .NRD(2)) u_pat (
    .clk(clk), .rst_n(rst_n), .clr(srst_wr),
    .we(wr_en && region == RG_PAT), .widx(idx[PAT_IW-1:0]),
    .wdat(wdata[PAT_W-1:0]), .ridx({idx[PAT_IW-1:0], pat_idx}), .rdat(pat_rd)
  );

  assign pix_rgb  = cpal_rd[0];
  assign cur_rgb  = cur_rd[0];
  assign pat_word = pat_rd[0];

  fbctl_scalars #(.DW(DW)) u_sc (
    .clk(clk), .rst_n(rst_n), .clr(srst_wr),
    .we_ctrl(wr_en && region == RG_CTRL),
    .we_top(wr_en && region == RG_TOP),
    .we_pos(wr_en && region == RG_POS),
    .we_width(wr_en && region == RG_WIDTH),
    .we_height(wr_en && region == RG_HEIGHT),
    .wdata(wdata),
    .ctrl_q(ctrl_word), .top_q(top_addr), .pos_q(cursor_pos),
    .width_q(width_px), .height_q(height_ln)
  );

  assign blank      = ctrl_word[CTRL_BLANK_BIT];
  assign cursor_off = ctrl_word[CTRL_CUROFF_BIT];
  assign depth_bpp  = depth_of(ctrl_word[CTRL_DEPTH_LSB +: 3]);

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (region)
      RG_CURPAL: rd_mux = DW'(cur_rd[1]);
      RG_PAT:    rd_mux = DW'(pat_rd[1]);
      RG_WIDTH:  rd_mux = width_to_bus(width_px);
      RG_HEIGHT: rd_mux = height_to_bus(height_ln);
      RG_CTRL:   rd_mux = ctrl_word;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
      err_pulse <= 1'b0;
      irq_clr   <= 1'b0;
      soft_rst  <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      rdata_vld <= rd_en;
      err_pulse <= (wr_en && !wr_mapped) || (rd_en && !rd_mapped);
      irq_clr   <= wr_en;
      soft_rst  <= srst_wr;
    end
  end
endmodule

// File: rtl/fbctl_chk.sv
module fbctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [20:0] addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        rdata_vld,
  input logic        err_pulse,
  input logic        irq_clr,
  input logic        soft_rst,
  input logic [31:0] width_px,
  input logic [31:0] height_ln,
  input logic [31:0] ctrl_word,
  input logic        wr_mapped,
  input logic        rd_mapped,
  input logic        timing_wr
);
  p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rdata_vld);
  p_no_stray_vld_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rdata_vld);
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> irq_clr);
  p_ack_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !irq_clr);
  p_bad_wr_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mapped) |=> err_pulse);
  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past((wr_en && !wr_mapped) || (rd_en && !rd_mapped)));
  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_mapped) |=> (rdata == 32'h0));
  p_srst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (width_px == 32'h0 && height_ln == 32'h0 && ctrl_word == 32'h0));
  p_timing_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_wr && !rd_en) |=> ($stable(width_px) && $stable(height_ln) &&
                               $stable(ctrl_word) && !err_pulse));
  p_width_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 21'h118) |=> (width_px == {$past(wdata[29:0]), 2'b00}));
endmodule

bind fbctl_regs fbctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld), .err_pulse(err_pulse),
  .irq_clr(irq_clr), .soft_rst(soft_rst), .width_px(width_px),
  .height_ln(height_ln), .ctrl_word(ctrl_word), .wr_mapped(wr_mapped),
  .rd_mapped(rd_mapped), .timing_wr(timing_wr)
);

// File: tb/sim_fbctl_regs.sv
`timescale 1ns/1ps
module sim_fbctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rdata_vld, err_pulse, irq_clr, soft_rst;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic [1:0]  cur_sel = '0;
  logic [23:0] cur_rgb;
  logic [8:0]  pat_idx = '0;
  logic [15:0] pat_word;
  logic [31:0] ctrl_word, top_addr, cursor_pos, width_px, height_ln;
  logic        blank, cursor_off;
  logic [4:0]  depth_bpp;

  always #2 clk = ~clk;

  fbctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld), .err_pulse(err_pulse),
    .irq_clr(irq_clr), .soft_rst(soft_rst), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
    .cur_sel(cur_sel), .cur_rgb(cur_rgb), .pat_idx(pat_idx), .pat_word(pat_word),
    .ctrl_word(ctrl_word), .blank(blank), .cursor_off(cursor_off),
    .depth_bpp(depth_bpp), .top_addr(top_addr), .cursor_pos(cursor_pos),
    .width_px(width_px), .height_ln(height_ln)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] bpp_model(input int code);
    int tbl[8] = '{1, 2, 4, 8, 15, 16, 0, 0};
    return 5'(tbl[code]);
  endfunction

  // Driver: write, then check the acknowledge pulse (R10) and the error flag
  task automatic bus_wr(input logic [20:0] a, input logic [31:0] d, input bit exp_err);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(irq_clr == 1'b1, "R10 ack after write", 32'(irq_clr), 32'd1);
    chk(err_pulse == exp_err, "R11 write error flag", 32'(err_pulse), 32'(exp_err));
  endtask

  // Driver: push expectation, issue read
  task automatic bus_rd(input logic [20:0] a, input logic [31:0] exp,
                        input bit exp_err, input string tag);
    q_data.push_back(exp); q_err.push_back(exp_err); q_tag.push_back(tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Monitor: pops on every valid read result (R12)
  always @(negedge clk) begin
    if (rst_n && rdata_vld) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R12 unexpected read data", rdata, 32'h0);
      end else begin
        logic [31:0] ed;
        logic ee;
        string tg;
        ed = q_data.pop_front(); ee = q_err.pop_front(); tg = q_tag.pop_front();
        chk(rdata == ed, tg, rdata, ed);
        chk(err_pulse == ee, {tg, " err"}, 32'(err_pulse), 32'(ee));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(width_px == 0 && height_ln == 0 && ctrl_word == 0, "R8 reset regs", width_px, 0);
    chk(depth_bpp == 5'd1, "R6 reset depth", 32'(depth_bpp), 1);
    chk(rdata_vld == 0 && irq_clr == 0 && err_pulse == 0, "R12 reset pulses",
        32'({rdata_vld, irq_clr, err_pulse}), 0);

    // R1 colour table
    bus_wr(21'h800, 32'hFF123456, 0);
    pix_idx = 8'd0; #0.1;
    chk(pix_rgb == 24'h123456, "R1 entry0", 32'(pix_rgb), 32'h123456);
    bus_wr(21'hFF8, 32'h00ABCDEF, 0);
    bus_wr(21'h80C, 32'h00010203, 0);
    bus_wr(21'h804, 32'h00777777, 0);
    pix_idx = 8'd255; #0.1;
    chk(pix_rgb == 24'hABCDEF, "R1 entry255", 32'(pix_rgb), 32'hABCDEF);
    pix_idx = 8'd1; #0.1;
    chk(pix_rgb == 24'h010203, "R1 entry1", 32'(pix_rgb), 32'h010203);
    pix_idx = 8'd0; #0.1;
    chk(pix_rgb == 24'h777777, "R1 entry0 via 0x804", 32'(pix_rgb), 32'h777777);
    bus_rd(21'h800, 32'h0, 1, "R1 colour table read unserved");

    // R2 cursor colours
    bus_wr(21'h508, 32'h55AA0000, 0);
    bus_wr(21'h510, 32'h0000BB00, 0);
    bus_wr(21'h518, 32'h000000CC, 0);
    bus_rd(21'h508, 32'h00AA0000, 0, "R2 read colour0");
    bus_rd(21'h510, 32'h0000BB00, 0, "R2 read colour1");
    bus_rd(21'h518, 32'h000000CC, 0, "R2 read colour2");
    for (int s = 0; s < 4; s++) begin
      logic [23:0] e;
      e = (s == 0) ? 24'hAA0000 : (s == 1) ? 24'h00BB00 : (s == 2) ? 24'h0000CC : 24'h0;
      cur_sel = 2'(s); #0.1;
      chk(cur_rgb == e, "R2 cursor lookup", 32'(cur_rgb), 32'(e));
    end
    bus_rd(21'h520, 32'h0, 1, "R11 read past cursor colours");

    // R3 cursor bitmap
    bus_wr(21'h1000, 32'hABCD1234, 0);
    bus_wr(21'h1FF8, 32'h0000BEEF, 0);
    bus_rd(21'h1000, 32'h00001234, 0, "R3 read word0");
    bus_rd(21'h1FF8, 32'h0000BEEF, 0, "R3 read word511");
    pat_idx = 9'd511; #0.1;
    chk(pat_word == 16'hBEEF, "R3 bitmap lookup", 32'(pat_word), 32'hBEEF);

    // R4 / R5 scaling
    bus_wr(21'h118, 32'h00000140, 0);
    chk(width_px == 32'h500, "R4 width", width_px, 32'h500);
    bus_rd(21'h118, 32'h140, 0, "R4 width read");
    bus_wr(21'h118, 32'hC0000001, 0);
    chk(width_px == 32'h4, "R4 width wrap", width_px, 32'h4);
    bus_rd(21'h118, 32'h1, 0, "R4 width wrap read");
    bus_wr(21'h150, 32'h00000301, 0);
    chk(height_ln == 32'h180, "R5 height", height_ln, 32'h180);
    bus_rd(21'h150, 32'h300, 0, "R5 height read");

    // R6 control decode, all depth codes
    for (int c = 0; c < 8; c++) begin
      logic [31:0] v;
      v = 32'h00800400 | (32'(c) << 20);
      bus_wr(21'h300, v, 0);
      chk(depth_bpp == bpp_model(c), "R6 depth decode", 32'(depth_bpp), 32'(bpp_model(c)));
    end
    chk(blank == 1 && cursor_off == 1, "R6 flags", 32'({blank, cursor_off}), 32'h3);
    bus_rd(21'h300, 32'h00F00400 | 32'h00800000, 0, "R6 ctrl read");
    bus_wr(21'h300, 32'h00300000, 0);
    chk(blank == 0 && cursor_off == 0 && depth_bpp == 5'd8, "R6 flags clear",
        32'({blank, cursor_off, depth_bpp}), 32'd8);

    // R7 top and position
    bus_wr(21'h400, 32'h00123000, 0);
    bus_wr(21'h638, 32'h00040020, 0);
    chk(top_addr == 32'h00123000, "R7 top", top_addr, 32'h00123000);
    chk(cursor_pos == 32'h00040020, "R7 position", cursor_pos, 32'h00040020);
    bus_rd(21'h400, 32'h0, 1, "R7 top read unserved");
    bus_rd(21'h638, 32'h0, 1, "R7 position read unserved");

    // R9 timing writes inert
    bus_wr(21'h000, 32'hFFFFFFFF, 0);
    bus_wr(21'h128, 32'hFFFFFFFF, 0);
    bus_wr(21'h170, 32'hFFFFFFFF, 0);
    bus_wr(21'h200, 32'hFFFFFFFF, 0);
    chk(width_px == 32'h4 && height_ln == 32'h180 && ctrl_word == 32'h00300000,
        "R9 timing writes inert", width_px, 32'h4);

    // R11 unserved write dropped
    bus_wr(21'h004, 32'hFFFFFFFF, 1);
    bus_wr(21'h100008, 32'hFFFFFFFF, 1);
    chk(width_px == 32'h4 && top_addr == 32'h00123000, "R11 unserved write dropped",
        width_px, 32'h4);
    @(negedge clk);
    chk(irq_clr == 0 && err_pulse == 0, "R10 pulses one cycle",
        32'({irq_clr, err_pulse}), 0);

    // R8 soft reset
    bus_wr(21'h100000, 32'h0, 0);
    chk(soft_rst == 1, "R8 soft reset pulse", 32'(soft_rst), 1);
    pix_idx = 8'd255; cur_sel = 2'd1; pat_idx = 9'd511; #0.1;
    chk(pix_rgb == 0 && cur_rgb == 0 && pat_word == 0, "R8 tables cleared",
        32'(pix_rgb), 0);
    chk(width_px == 0 && height_ln == 0 && ctrl_word == 0 && top_addr == 0 &&
        cursor_pos == 0, "R8 regs cleared", top_addr, 0);
    @(negedge clk);
    chk(soft_rst == 0, "R8 pulse one cycle", 32'(soft_rst), 0);
    bus_rd(21'h1000, 32'h0, 0, "R8 bitmap cleared read");
    @(negedge clk);
    chk(q_data.size() == 0, "R12 all reads returned", 32'(q_data.size()), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule